// File: doc/BRIEF.md
# Skew-Tolerant Bus Width Bridge

This block carries a streamed test-data bus from one clock-tree region to another when the skew between the two regions is unknown. The transmit half runs on the sending region's clock. It packs each pair of consecutive narrow words into one word of twice the width, and that wide word changes only once every two fast cycles. The receive half runs on the receiving region's clock. It samples the wide word in the middle of its two-cycle window and unpacks it back into narrow words at the full rate.

The wide, slow intermediate bus gives up to about one fast period of skew tolerance. The stream itself sees only a fixed delay: no bit is lost, duplicated or reordered.

Both halves take the same synchronous active-low reset. The first transmit edge after reset is phase zero, so the delay is the same on every run. The two halves are separate modules. They can therefore also be used in the other order, for example to turn a wide, slow pin interface into a narrow, fast internal bus and back.

Top module: `skew_width_bridge`

## Requirements
- R1: Each update of `mid_bus` places the earlier of two consecutive `tx_data` words in bits [N-1:0] and the later word in bits [2N-1:N].
- R2: `mid_bus` changes only on odd-numbered transmit edges, counting the first edge after reset release as edge 0. It holds its value across the following even edge.
- R3: The receive half sends out the lower half of each sampled wide word first and the upper half on the next receive cycle.
- R4: A `tx_data` word captured on transmit edge k appears on `rx_data` right after receive edge k+3. Before edge 3, `rx_data` is zero.
- R5: While `rst_n` is low, `rx_data` and `mid_bus` are cleared to zero on the next edge of their own clock.
- R6: After every reset release, the first transmit edge is phase zero, so repeated runs show the same latency and the same `mid_bus` packing.
- R7: Behaviour is the same for any fixed lag of the receive clock behind the transmit clock from zero up to just under one fast period.
- R8: Over a long arbitrary stream, `rx_data` equals `tx_data` delayed by the constant of R4, with no loss or reordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Fast clock of the transmitting region |
| clk_rx | input | 1 | Fast clock of the receiving region, same frequency, fixed unknown phase |
| rst_n | input | 1 | Synchronous active-low reset shared by both halves |
| tx_data | input | NARROW_W | Narrow fast stream entering the bridge |
| mid_bus | output | 2*NARROW_W | Wide, slow bus crossing between the regions |
| rx_data | output | NARROW_W | Narrow fast stream leaving the bridge |

## Verification
The assertions assume three things. First, the receive clock lags the transmit clock by less than one fast period, so `mid_bus` is steady at every receive sampling edge. Second, both domains see the release of `rst_n` on the same edge index. Third, `tx_data` is steady around each transmit edge. The bench keeps within these limits in the following ways. It changes `tx_data` and `rst_n` only at the falling edge of the transmit clock. It uses receive lags of 1 and 4 units against a 10-unit period. It alters the lag only while reset is held.

// File: rtl/swb_pkg.sv
// Shared types for the skew-tolerant width bridge.
// Assumes: both halves run at the same fast frequency.
package swb_pkg;

    // Position inside the two-fast-cycle window of one wide word.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } half_phase_e;

endpackage

// File: rtl/swb_phase_toggle.sv
// Two-state phase tracker for one clock region.
// Assumes: the reset is synchronous to clk. The first edge after release is PH_EVEN.
module swb_phase_toggle
    import swb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output half_phase_e phase
);

    // Alternate between the two halves of each wide-word window.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_EVEN;
        else        phase <= (phase == PH_EVEN) ? PH_ODD : PH_EVEN;
    end

endmodule

// File: rtl/swb_divider.sv
// Transmit half: packs two consecutive narrow words into one wide word.
// The earlier word goes in the low half. The wide output updates on PH_ODD edges only.
// Assumes: clocked by the transmitting region, phase from a local swb_phase_toggle.
module swb_divider
    import swb_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int WIDE_W  = 2 * NARROW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  half_phase_e         phase,
    input  logic [NARROW_W-1:0] narrow_in,
    output logic [WIDE_W-1:0]   wide_out
);

    logic [NARROW_W-1:0] early_q;

    // Hold the first word of a pair, then launch the packed pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q  <= '0;
            wide_out <= '0;
        end else if (phase == PH_EVEN) begin
            early_q  <= narrow_in;
        end else begin
            wide_out <= {narrow_in, early_q};
        end
    end

endmodule

// File: rtl/swb_multiplier.sv
// Receive half: samples the wide word on PH_EVEN edges, which fall in the middle
// of its two-cycle window. It then emits the low half and after it the high half.
// Assumes: clocked by the receiving region, lagging the transmit clock by less than one period.
module swb_multiplier
    import swb_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int WIDE_W  = 2 * NARROW_W,
    localparam int LANES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  half_phase_e         phase,
    input  logic [WIDE_W-1:0]   wide_in,
    output logic [NARROW_W-1:0] narrow_out
);

    logic [WIDE_W-1:0]   hold_q;
    logic [NARROW_W-1:0] lane [LANES];

    // Split the held wide word into its narrow lanes.
    for (genvar h = 0; h < LANES; h++) begin : g_lane
        assign lane[h] = hold_q[h*NARROW_W +: NARROW_W];
    end

    // Capture mid-window and serialise the lanes, low lane first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            narrow_out <= '0;
        end else if (phase == PH_EVEN) begin
            hold_q     <= wide_in;
            narrow_out <= lane[1];
        end else begin
            narrow_out <= lane[0];
        end
    end

endmodule

// File: rtl/skew_width_bridge.sv
// Top: transmit-side divider and receive-side multiplier joined by the wide bus.
// Each half has its own phase tracker on its own region clock.
// Assumes: both clocks have the same frequency, and the rx clock lags tx by less than one period.
module skew_width_bridge
    import swb_pkg::*;
#(
    parameter int NARROW_W = 8,
    localparam int WIDE_W  = 2 * NARROW_W
) (
    input  logic                clk_tx,
    input  logic                clk_rx,
    input  logic                rst_n,
    input  logic [NARROW_W-1:0] tx_data,
    output logic [WIDE_W-1:0]   mid_bus,
    output logic [NARROW_W-1:0] rx_data
);

    half_phase_e tx_phase;
    half_phase_e rx_phase;

    swb_phase_toggle u_tx_phase (
        .clk   (clk_tx),
        .rst_n (rst_n),
        .phase (tx_phase)
    );

    swb_phase_toggle u_rx_phase (
        .clk   (clk_rx),
        .rst_n (rst_n),
        .phase (rx_phase)
    );

    swb_divider #(.NARROW_W(NARROW_W)) u_div (
        .clk       (clk_tx),
        .rst_n     (rst_n),
        .phase     (tx_phase),
        .narrow_in (tx_data),
        .wide_out  (mid_bus)
    );

    swb_multiplier #(.NARROW_W(NARROW_W)) u_mul (
        .clk        (clk_rx),
        .rst_n      (rst_n),
        .phase      (rx_phase),
        .wide_in    (mid_bus),
        .narrow_out (rx_data)
    );

endmodule

// File: rtl/skew_width_bridge_chk.sv
// Checker for skew_width_bridge, bound to it below.
// Assumes: rst_n is low from time zero, and the rx lag is below one fast period.
module skew_width_bridge_chk #(
    parameter int N = 8
) (
    input logic           clk_tx,
    input logic           clk_rx,
    input logic           rst_n,
    input logic [N-1:0]   tx_data,
    input logic [2*N-1:0] mid_bus,
    input logic [N-1:0]   rx_data,
    input logic           tx_ph,
    input logic           rx_ph
);

    // R1: an update packs the previous word low and the current word high.
    a_r1_pack_order: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (tx_ph == 1'b1) |=> (mid_bus == {$past(tx_data), $past(tx_data, 2)}));

    // R2: the wide bus holds across the even transmit edge.
    a_r2_hold_even: assert property (@(posedge clk_tx) disable iff (!rst_n)
        (tx_ph == 1'b0) |=> $stable(mid_bus));

    // R3: the low half of a sampled wide word leaves first.
    a_r3_low_first: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (rx_ph == 1'b0) |-> ##2 (rx_data == $past(mid_bus[N-1:0], 2)));

    // R3: the high half follows one receive cycle later.
    a_r3_high_next: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (rx_ph == 1'b0) |-> ##3 (rx_data == $past(mid_bus[2*N-1:N], 3)));

    // R5: reset clears the receive output.
    a_r5_rx_clear: assert property (@(posedge clk_rx)
        !rst_n |=> (rx_data == '0));

    // R5: reset clears the wide bus.
    a_r5_mid_clear: assert property (@(posedge clk_tx)
        !rst_n |=> (mid_bus == '0));

endmodule

bind skew_width_bridge skew_width_bridge_chk #(.N(NARROW_W)) u_chk (
    .clk_tx  (clk_tx),
    .clk_rx  (clk_rx),
    .rst_n   (rst_n),
    .tx_data (tx_data),
    .mid_bus (mid_bus),
    .rx_data (rx_data),
    .tx_ph   (tx_phase),
    .rx_ph   (rx_phase)
);

// File: tb/skew_width_bridge_bench.sv
module skew_width_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW         = 8;
    localparam int SKEW_A     = 1;
    localparam int SKEW_B     = 4;
    localparam int TBL_LEN    = 12;

    // Each entry: {word driven before transmit edge k, rx_data expected after receive edge k}.
    localparam logic [2*NW-1:0] VEC [TBL_LEN] = '{
        16'h1100, 16'h2200, 16'h3300, 16'h4411,
        16'hA522, 16'h5A33, 16'hFF44, 16'h00A5,
        16'h815A, 16'h7EFF, 16'hC300, 16'h3C81
    };

    logic          clk_tx = 1'b0;
    logic          clk_rx = 1'b0;
    logic          rst_n  = 1'b0;
    logic [NW-1:0] tx_data = '0;
    logic [2*NW-1:0] mid_bus;
    logic [NW-1:0] rx_data;
    int            skew_now = SKEW_A;
    int            tests = 0;
    int            fails = 0;
    bit            done  = 1'b0;

    skew_width_bridge #(.NARROW_W(NW)) u_skew_width_bridge (
        .clk_tx  (clk_tx),
        .clk_rx  (clk_rx),
        .rst_n   (rst_n),
        .tx_data (tx_data),
        .mid_bus (mid_bus),
        .rx_data (rx_data)
    );

    always #(CLK_PERIOD/2) clk_tx = ~clk_tx;
    always @(clk_tx) clk_rx <= #(skew_now) clk_tx;

    function automatic logic [NW-1:0] word_at(input int mode, input int k);
        if (k < 0) return '0;
        case (mode)
            0: return (k < TBL_LEN) ? VEC[k][2*NW-1:NW] : '0;
            1: return NW'((k * 29 + 7) ^ (k >> 3));
            default: return (k == 4) ? 8'hAB : ((k == 5) ? 8'hCD : 8'h00);
        endcase
    endfunction

    function automatic logic [2*NW-1:0] exp_mid(input int mode, input int k);
        if (k == 0) return '0;
        if (k % 2 == 1) return {word_at(mode, k), word_at(mode, k - 1)};
        return {word_at(mode, k - 1), word_at(mode, k - 2)};
    endfunction

    function automatic logic [NW-1:0] exp_out(input int mode, input int k);
        if (mode == 0 && k < TBL_LEN) return VEC[k][NW-1:0];
        return (k < 3) ? '0 : word_at(mode, k - 3);
    endfunction

    task automatic chk(input string req, input logic [2*NW-1:0] act, input logic [2*NW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Reset with a chosen rx lag, then stream n words and check both buses per edge.
    task automatic run_stream(input int mode, input int n, input int skew, input string tag);
        @(negedge clk_tx);
        rst_n   = 1'b0;
        tx_data = '0;
        repeat (3) @(negedge clk_tx);
        skew_now = skew;
        repeat (3) @(negedge clk_tx);
        @(negedge clk_rx);
        chk("R5 rx_data in reset", {8'h00, rx_data}, '0);
        chk("R5 mid_bus in reset", mid_bus, '0);
        @(negedge clk_tx);
        rst_n   = 1'b1;
        tx_data = word_at(mode, 0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk_tx);
            chk({"R1 R2 R6 mid_bus ", tag}, mid_bus, exp_mid(mode, k));
            tx_data = word_at(mode, k + 1);
            @(negedge clk_rx);
            chk({"R3 R4 R7 rx_data ", tag}, {8'h00, rx_data}, {8'h00, exp_out(mode, k)});
        end
    endtask

    initial begin
        run_stream(0, TBL_LEN, SKEW_A, "table lag1");
        run_stream(2, 12, SKEW_B, "impulse lag4 R3");
        run_stream(1, 64, SKEW_A, "long R8");
        run_stream(0, TBL_LEN, SKEW_B, "table rerun lag4 R6");
        run_stream(1, 40, SKEW_B, "long lag4 R8");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R4 watchdog: got hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule